// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

The block holds a bank of hardware semaphores that two agents, called the left port and the right port, use to reserve shared resources. Each port can issue, in any cycle, a semaphore write and a semaphore read. A write carries an address and a data word, and only bit 0 of the word counts. Writing 0 asks for the semaphore and writing 1 gives it up. A read returns that port's view of one semaphore, copied onto every data bit: all zeros while that port owns it, and all ones otherwise.

Ownership follows fixed rules. A free semaphore goes to the first port that asks for it. A port that does not own the semaphore cannot take it, but its request is remembered. When the owner releases, the semaphore passes straight to the waiting port. If that port instead writes 1, its request is withdrawn. When both ports ask for the same free semaphore in the same cycle, the left port wins and the right port's request is kept waiting.

Read results are captured in a register one cycle after the read strobe. A write in the same cycle therefore cannot disturb the value returned. The asynchronous active-low reset frees every semaphore and clears every waiting request.

Top module: `dual_port_semaphore`

## Requirements
- R1: After reset every semaphore is free with no request waiting, so a read from either port returns 8'hFF.
- R2: A read strobe in cycle N sets that port's read data at the clock edge ending cycle N. The value is 8'h00 if the port owns the addressed semaphore at that edge and 8'hFF if not. Without a read strobe the read data holds its value.
- R3: A write of 0 by one port to a free semaphore makes that port the owner. It then reads 8'h00 and the other port reads 8'hFF.
- R4: A write of 0 by the port that does not own a semaphore leaves ownership unchanged. A write of 0 by the owner also leaves ownership unchanged.
- R5: When the owner writes 1 while the other port has a request waiting, the semaphore passes at once to the other port.
- R6: When the owner writes 1 with no request waiting from the other port, the semaphore becomes free and both ports read 8'hFF.
- R7: A write of 1 by a port whose request is waiting withdraws that request. A later release by the owner then frees the semaphore.
- R8: When both ports write 0 to the same free semaphore in the same cycle, the left port becomes the owner and the right port's request is left waiting.
- R9: Only bit 0 of the write data is used. Bits 7 to 1 have no effect.
- R10: A read returns the state from before any write in the same cycle, whether that write comes from either port.
- R11: Each of the eight semaphores, selected by a 3-bit address, changes only on writes to its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; frees all semaphores |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | 3 | Left port semaphore address |
| l_wdata | input | 8 | Left port write data; bit 0 is the value written |
| l_rdata | output | 8 | Left port registered read data |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | 3 | Right port semaphore address |
| r_wdata | input | 8 | Right port write data; bit 0 is the value written |
| r_rdata | output | 8 | Right port registered read data |

## Verification
A directed script walks one semaphore through the ownership cases and reads both ports after each step: grant, denial, handover, handover back, free release, a withdrawn request and a same-cycle tie. These steps tell apart a handover to the waiting port and a plain release to the free state. A read placed in the same cycle as the other port's releasing write separates capture before the write from capture after it. Words with the upper bits toggled and a check of untouched addresses show that bit 0 alone decides and that addresses stay separate. A long stretch of random traffic follows, with addresses crowded onto a few semaphores so that ties and overlapping requests happen often, and a behavioural model checks it on every cycle.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // ownership of one semaphore cell
  typedef enum logic [1:0] {
    SEM_FREE  = 2'b00,
    SEM_LEFT  = 2'b01,
    SEM_RIGHT = 2'b10
  } sem_state_e;
endpackage

// File: rtl/sema_wr_decode.sv
module sema_wr_decode #(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = $clog2(NUM_SEMA)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                val,
  output logic [NUM_SEMA-1:0] req,
  output logic [NUM_SEMA-1:0] rel
);
  for (genvar i = 0; i < NUM_SEMA; i++) begin : g_dec
    logic hit;
    assign hit    = wr && (addr == ADDR_W'(i));
    assign req[i] = hit && !val;
    assign rel[i] = hit &&  val;
  end

  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req | rel) && ((req | rel) == '0 || wr));
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
#(
  parameter bit TIE_TO_LEFT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  sem_state_e st_q, st_d;
  logic       wait_q, wait_d;   // non-owner has a request waiting
  logic       wait_upd;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    wait_upd = wait_q;
    unique case (st_q)
      SEM_FREE: begin
        wait_d = 1'b0;
        if (req_l && req_r) begin
          st_d   = TIE_TO_LEFT ? SEM_LEFT : SEM_RIGHT;
          wait_d = 1'b1;
        end else if (req_l) begin
          st_d = SEM_LEFT;
        end else if (req_r) begin
          st_d = SEM_RIGHT;
        end
      end
      SEM_LEFT: begin
        if (req_r)      wait_upd = 1'b1;
        else if (rel_r) wait_upd = 1'b0;
        if (rel_l) begin
          st_d   = wait_upd ? SEM_RIGHT : SEM_FREE;
          wait_d = 1'b0;
        end else begin
          wait_d = wait_upd;
        end
      end
      SEM_RIGHT: begin
        if (req_l)      wait_upd = 1'b1;
        else if (rel_l) wait_upd = 1'b0;
        if (rel_r) begin
          st_d   = wait_upd ? SEM_LEFT : SEM_FREE;
          wait_d = 1'b0;
        end else begin
          wait_d = wait_upd;
        end
      end
      default: begin
        st_d   = SEM_FREE;
        wait_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEM_FREE;
      wait_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
    end
  end

  assign own_l = (st_q == SEM_LEFT);
  assign own_r = (st_q == SEM_RIGHT);

  assert_free_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEM_FREE && req_l && !req_r) |=> (own_l && !own_r));
  assert_nonowner_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEM_LEFT && !rel_l) |=> own_l);
  assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEM_RIGHT && rel_r && req_l) |=> own_l);
  assert_free_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEM_LEFT && rel_l && !wait_q && !req_r) |=> (!own_l && !own_r));
  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEM_LEFT && rel_r) |=> !wait_q);
  assert_tie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEM_FREE && req_l && req_r) |=> (wait_q && (own_l == TIE_TO_LEFT)));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_l || rel_l || req_r || rel_r) |=> ($stable(own_l) && $stable(own_r)));
endmodule

// File: rtl/sema_rd_port.sv
module sema_rd_port #(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = $clog2(NUM_SEMA),
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SEMA-1:0] own,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] rdata_d;
  logic              taken;

  assign taken   = own[addr];
  assign rdata_d = {DATA_W{!taken}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '1;
    else if (rd) rdata <= rdata_d;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  assert_replicated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rdata) == 0) || ($countones(rdata) == DATA_W));
endmodule

// File: rtl/dual_port_semaphore.sv
module dual_port_semaphore #(
  parameter int NUM_SEMA    = 8,
  parameter int DATA_W      = 8,
  parameter bit TIE_TO_LEFT = 1'b1,
  localparam int ADDR_W     = $clog2(NUM_SEMA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_SEMA-1:0] req_l, rel_l, req_r, rel_r;
  logic [NUM_SEMA-1:0] own_l, own_r;
  logic                unused_hi;

  assign unused_hi = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  sema_wr_decode #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W)) u_dec_l (
    .clk(clk), .rst_n(rst_n), .wr(l_wr), .addr(l_addr), .val(l_wdata[0]),
    .req(req_l), .rel(rel_l));
  sema_wr_decode #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W)) u_dec_r (
    .clk(clk), .rst_n(rst_n), .wr(r_wr), .addr(r_addr), .val(r_wdata[0]),
    .req(req_r), .rel(rel_r));

  for (genvar i = 0; i < NUM_SEMA; i++) begin : g_cell
    sema_cell #(.TIE_TO_LEFT(TIE_TO_LEFT)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l[i]), .rel_l(rel_l[i]),
      .req_r(req_r[i]), .rel_r(rel_r[i]),
      .own_l(own_l[i]), .own_r(own_r[i]));
  end

  sema_rd_port #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd(l_rd), .addr(l_addr), .own(own_l), .rdata(l_rdata));
  sema_rd_port #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd(r_rd), .addr(r_addr), .own(own_r), .rdata(r_rdata));

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);
  assert_read_sees_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd |=> (l_rdata == {DATA_W{!$past(own_l[l_addr])}}));
endmodule

// File: tb/dual_port_semaphore_test.sv
`timescale 1ns/1ps
module dual_port_semaphore_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_wr = 0, l_rd = 0, r_wr = 0, r_rd = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_wdata = 0, r_wdata = 0;
  logic [7:0] l_rdata, r_rdata;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // reference model: owner 0 none, 1 left, 2 right
  int owner [8];
  bit waitq [8];
  logic [7:0] exp_l = 8'hFF, exp_r = 8'hFF;

  always #2 clk = ~clk;

  dual_port_semaphore uut (
    .clk(clk), .rst_n(rst_n),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  initial for (int a = 0; a < 8; a++) begin owner[a] = 0; waitq[a] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 8; a++) begin owner[a] = 0; waitq[a] = 0; end
      exp_l = 8'hFF; exp_r = 8'hFF;
    end else begin
      if (l_rd) exp_l = (owner[l_addr] == 1) ? 8'h00 : 8'hFF;
      if (r_rd) exp_r = (owner[r_addr] == 2) ? 8'h00 : 8'hFF;
      for (int a = 0; a < 8; a++) begin
        bit lq, lr, rq, rr;
        lq = l_wr && l_addr == a && !l_wdata[0];
        lr = l_wr && l_addr == a &&  l_wdata[0];
        rq = r_wr && r_addr == a && !r_wdata[0];
        rr = r_wr && r_addr == a &&  r_wdata[0];
        if (owner[a] == 0) begin
          waitq[a] = 0;
          if (lq) begin owner[a] = 1; waitq[a] = rq; end
          else if (rq) owner[a] = 2;
        end else if (owner[a] == 1) begin
          if (rq) waitq[a] = 1; else if (rr) waitq[a] = 0;
          if (lr) begin owner[a] = waitq[a] ? 2 : 0; waitq[a] = 0; end
        end else begin
          if (lq) waitq[a] = 1; else if (lr) waitq[a] = 0;
          if (rr) begin owner[a] = waitq[a] ? 1 : 0; waitq[a] = 0; end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    vectors++;
    if (l_rdata !== exp_l || r_rdata !== exp_r) begin
      fails++;
      $display("FAIL R2 model: left %h exp %h, right %h exp %h", l_rdata, exp_l, r_rdata, exp_r);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit lw, input int la, input logic [7:0] ld,
                    input bit rw, input int ra, input logic [7:0] rdv);
    @(negedge clk);
    l_wr = lw; l_addr = 3'(la); l_wdata = ld;
    r_wr = rw; r_addr = 3'(ra); r_wdata = rdv;
    @(negedge clk);
    l_wr = 0; r_wr = 0;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [7:0] el, input logic [7:0] er);
    l_rd = 1; r_rd = 1; l_addr = 3'(a); r_addr = 3'(a);
    @(negedge clk);
    l_rd = 0; r_rd = 0;
    chk({tag, " left"}, l_rdata, el);
    chk({tag, " right"}, r_rdata, er);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset left", l_rdata, 8'hFF);
    chk("R1 reset right", r_rdata, 8'hFF);
    for (int a = 0; a < 8; a++) begin @(negedge clk); rdchk("R1 all free", a, 8'hFF, 8'hFF); end

    wr(1, 3, 8'h00, 0, 0, 8'h00); rdchk("R3 left grant", 3, 8'h00, 8'hFF);
    wr(0, 0, 8'h00, 1, 3, 8'h00); rdchk("R4 right denied", 3, 8'h00, 8'hFF);
    wr(1, 3, 8'h01, 0, 0, 8'h00); rdchk("R5 handover to right", 3, 8'hFF, 8'h00);
    wr(1, 3, 8'h00, 0, 0, 8'h00); rdchk("R4 left denied", 3, 8'hFF, 8'h00);
    wr(0, 0, 8'h00, 1, 3, 8'h01); rdchk("R5 handover to left", 3, 8'h00, 8'hFF);
    wr(1, 3, 8'h01, 0, 0, 8'h00); rdchk("R6 free release", 3, 8'hFF, 8'hFF);
    wr(0, 0, 8'h00, 1, 3, 8'h00); rdchk("R3 right grant", 3, 8'hFF, 8'h00);
    wr(1, 3, 8'h00, 0, 0, 8'h00);
    wr(1, 3, 8'h01, 0, 0, 8'h00); rdchk("R7 cancel keeps owner", 3, 8'hFF, 8'h00);
    wr(0, 0, 8'h00, 1, 3, 8'h01); rdchk("R7 release after cancel frees", 3, 8'hFF, 8'hFF);

    wr(1, 5, 8'h00, 1, 5, 8'h00); rdchk("R8 tie to left", 5, 8'h00, 8'hFF);
    wr(1, 5, 8'h01, 0, 0, 8'h00); rdchk("R8 right waiting after tie", 5, 8'hFF, 8'h00);
    wr(0, 0, 8'h00, 1, 5, 8'h01); rdchk("R6 right release", 5, 8'hFF, 8'hFF);

    wr(1, 1, 8'hFE, 0, 0, 8'h00); rdchk("R9 FE requests", 1, 8'h00, 8'hFF);
    wr(0, 0, 8'h00, 1, 1, 8'hF0); rdchk("R9 right F0 requests while owned", 1, 8'h00, 8'hFF);
    wr(1, 1, 8'h81, 0, 0, 8'h00); rdchk("R9 81 releases", 1, 8'hFF, 8'h00);
    rdchk("R11 neighbour free", 2, 8'hFF, 8'hFF);
    rdchk("R11 other address free", 0, 8'hFF, 8'hFF);

    // R10: left reads while right releases to the waiting left port
    wr(0, 0, 8'h00, 1, 6, 8'h00);
    wr(1, 6, 8'h00, 0, 0, 8'h00);
    @(negedge clk);
    l_rd = 1; l_addr = 3'd6; r_wr = 1; r_addr = 3'd6; r_wdata = 8'h01;
    @(negedge clk);
    l_rd = 0; r_wr = 0;
    chk("R10 read before write", l_rdata, 8'hFF);
    repeat (3) @(negedge clk);
    chk("R2 hold without strobe", l_rdata, 8'hFF);
    rdchk("R10 after handover", 6, 8'h00, 8'hFF);
    wr(1, 6, 8'h01, 0, 0, 8'h00);
    wr(0, 0, 8'h00, 1, 1, 8'h01);

    // random traffic on crowded addresses
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      l_wr = 1'($urandom); r_wr = 1'($urandom);
      l_rd = 1'($urandom); r_rd = 1'($urandom);
      l_addr = 3'($urandom % 3); r_addr = 3'($urandom % 3);
      l_wdata = 8'($urandom); r_wdata = 8'($urandom);
    end
    @(negedge clk);
    l_wr = 0; r_wr = 0; l_rd = 0; r_rd = 0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule